// File: doc/BRIEF.md
# Clock Failure Fallback Controller

This block runs in the slow clock domain and steers the clock-selection controls toward safe sources once an external oscillator monitor reports that the main crystal has stopped. It does not switch clocks itself. It produces the effective select values that the clock multiplexers downstream use. When no failure is present, each effective select is a registered copy of the value software configured.

When a failure is reported, the block does three things. It forces the main-clock select to the internal fast RC oscillator. It forces that oscillator's enable on. It raises a fault output. If the main clock was running from the crystal and the master clock was taken from a PLL, the master-clock select is first moved to the main clock. The main-clock select moves to the RC oscillator one slow cycle later.

The overrides stay in place until software pulses a clear strobe while the failure indication is low. Until then, changes to the configured selects have no effect on the overridden outputs.

Top module: `clk_fail_fallback`

## Requirements
- R1: While reset is high, `fault_out` is 0 and each effective output takes the value of its configured input at every clock edge.
- R2: With no failure pending, each effective output equals its configured input as registered at the previous clock edge. Main-select encoding is 1 = crystal and 0 = fast RC. Master-select codes are 0 = slow clock, 1 = main clock, 2 = PLL.
- R3: Suppose `fail_in` is first sampled high at edge k, and the path is not the PLL path. Then `eff_main_sel` becomes 0 and `fault_out` becomes 1 after edge k+1, so the switch takes 2 edges in total.
- R4: From the edge where `fault_out` rises, `eff_rc_en` is 1 even if `cfg_rc_en` is 0.
- R5: The PLL path is `cfg_main_sel`=1 together with `cfg_mck_sel`=2, sampled at edge k. On this path, `eff_mck_sel` becomes 1 and `fault_out` becomes 1 after edge k+1, while `eff_main_sel` stays 1. `eff_main_sel` becomes 0 after edge k+2, so the switch takes 3 edges in total.
- R6: Once set, `fault_out` stays 1 on every edge at which `fault_clr` is low.
- R7: While the fault is held, writes to `cfg_main_sel`, `cfg_rc_en` and, on the PLL path, `cfg_mck_sel` do not change the overridden outputs.
- R8: A `fault_clr` pulse sampled while `fail_in` is high leaves `fault_out` at 1 and keeps the overrides.
- R9: A `fault_clr` pulse sampled while `fail_in` is low and the fault is held clears `fault_out` at that edge. At the same edge, every effective output returns to its configured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_in | input | 1 | Failure indication from the oscillator monitor |
| fault_clr | input | 1 | Software fault-clear strobe |
| cfg_main_sel | input | 1 | Configured main-clock source (1 crystal, 0 fast RC) |
| cfg_mck_sel | input | MCK_W | Configured master-clock source code |
| cfg_rc_en | input | 1 | Configured fast RC oscillator enable |
| eff_main_sel | output | 1 | Effective main-clock source |
| eff_mck_sel | output | MCK_W | Effective master-clock source code |
| eff_rc_en | output | 1 | Effective fast RC oscillator enable |
| fault_out | output | 1 | Latched clock fault indication |

## Verification
If the sequencer takes the wrong path, the ports show it within one edge. In that case `eff_main_sel` drops at the same edge as `fault_out` on the PLL path, or `eff_mck_sel` changes when it should not. A hold state that is lost or released too early shows as a configured value reaching an overridden output, or as `fault_out` falling, at the first edge after the error. A wrongly accepted clear is visible at the very edge that sampled it.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_MCKSW = 2'd2,
    ST_HOLD  = 2'd3
  } cfd_state_t;

  localparam logic MAIN_SRC_RC   = 1'b0;
  localparam logic MAIN_SRC_XTAL = 1'b1;
endpackage

// File: rtl/cfd_seq.sv
module cfd_seq
  import cfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fail_in,
  input  logic clr_in,
  input  logic pll_path_in,
  output logic force_main_n,
  output logic force_mck_n,
  output logic fault_n
);
  cfd_state_t state_q, state_n;
  logic       pll_lat_q;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (fail_in) state_n = ST_CAPT;
      ST_CAPT:  state_n = pll_lat_q ? ST_MCKSW : ST_HOLD;
      ST_MCKSW: state_n = ST_HOLD;
      ST_HOLD:  if (clr_in && !fail_in) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pll_lat_q <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == ST_IDLE && fail_in) pll_lat_q <= pll_path_in;
      else if (state_n == ST_IDLE)       pll_lat_q <= 1'b0;
    end
  end

  // Steering decided from the next state so the output registers update together
  assign fault_n      = (state_n == ST_MCKSW) || (state_n == ST_HOLD);
  assign force_main_n = (state_n == ST_HOLD);
  assign force_mck_n  = (state_n == ST_MCKSW) || (state_n == ST_HOLD && pll_lat_q);

  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !clr_in) |=> (state_q == ST_HOLD));
  assert_clr_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && fail_in) |=> (state_q == ST_HOLD));
  assert_pll_two_step_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MCKSW) |-> $past(state_q == ST_CAPT));
endmodule

// File: rtl/cfd_out_reg.sv
module cfd_out_reg
  import cfd_pkg::*;
#(
  parameter int MCK_W         = 2,
  parameter int MCK_MAIN_CODE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_main_sel,
  input  logic [MCK_W-1:0] cfg_mck_sel,
  input  logic             cfg_rc_en,
  input  logic             force_main_n,
  input  logic             force_mck_n,
  input  logic             fault_n,
  output logic             eff_main_sel,
  output logic [MCK_W-1:0] eff_mck_sel,
  output logic             eff_rc_en,
  output logic             fault_q
);
  localparam logic [MCK_W-1:0] MCK_MAIN = MCK_W'(MCK_MAIN_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_main_sel <= cfg_main_sel;
      eff_mck_sel  <= cfg_mck_sel;
      eff_rc_en    <= cfg_rc_en;
      fault_q      <= 1'b0;
    end else begin
      eff_main_sel <= force_main_n ? MAIN_SRC_RC : cfg_main_sel;
      eff_mck_sel  <= force_mck_n ? MCK_MAIN : cfg_mck_sel;
      eff_rc_en    <= fault_n | cfg_rc_en;
      fault_q      <= fault_n;
    end
  end

  assert_rc_forced_R4: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> eff_rc_en);
endmodule

// File: rtl/clk_fail_fallback.sv
module clk_fail_fallback
  import cfd_pkg::*;
#(
  parameter int MCK_W         = 2,
  parameter int MCK_MAIN_CODE = 1,
  parameter int MCK_PLL_CODE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_in,
  input  logic             fault_clr,
  input  logic             cfg_main_sel,
  input  logic [MCK_W-1:0] cfg_mck_sel,
  input  logic             cfg_rc_en,
  output logic             eff_main_sel,
  output logic [MCK_W-1:0] eff_mck_sel,
  output logic             eff_rc_en,
  output logic             fault_out
);
  localparam logic [MCK_W-1:0] MCK_PLL  = MCK_W'(MCK_PLL_CODE);
  localparam logic [MCK_W-1:0] MCK_MAIN = MCK_W'(MCK_MAIN_CODE);

  logic pll_path, force_main_n, force_mck_n, fault_n;

  assign pll_path = (cfg_main_sel == MAIN_SRC_XTAL) && (cfg_mck_sel == MCK_PLL);

  cfd_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .fail_in      (fail_in),
    .clr_in       (fault_clr),
    .pll_path_in  (pll_path),
    .force_main_n (force_main_n),
    .force_mck_n  (force_mck_n),
    .fault_n      (fault_n)
  );

  cfd_out_reg #(
    .MCK_W         (MCK_W),
    .MCK_MAIN_CODE (MCK_MAIN_CODE)
  ) u_out (
    .clk          (clk),
    .rst          (rst),
    .cfg_main_sel (cfg_main_sel),
    .cfg_mck_sel  (cfg_mck_sel),
    .cfg_rc_en    (cfg_rc_en),
    .force_main_n (force_main_n),
    .force_mck_n  (force_mck_n),
    .fault_n      (fault_n),
    .eff_main_sel (eff_main_sel),
    .eff_mck_sel  (eff_mck_sel),
    .eff_rc_en    (eff_rc_en),
    .fault_q      (fault_out)
  );

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (fault_out && !fault_clr) |=> fault_out);
  assert_main_on_rc_R3: assert property (@(posedge clk) disable iff (rst)
    (fault_out && $past(fault_out)) |-> (eff_main_sel == MAIN_SRC_RC));
  assert_pll_first_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault_out) && eff_main_sel == MAIN_SRC_XTAL) |-> (eff_mck_sel == MCK_MAIN));
  assert_release_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_out) |-> ($past(fault_clr) && !$past(fail_in)));
endmodule

// File: tb/clk_fail_fallback_test.sv
module clk_fail_fallback_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fail_in = 1'b0;
  logic       fault_clr = 1'b0;
  logic       cfg_main_sel = 1'b1;
  logic [1:0] cfg_mck_sel = 2'd1;
  logic       cfg_rc_en = 1'b0;
  logic       eff_main_sel, eff_rc_en, fault_out;
  logic [1:0] eff_mck_sel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_fail_fallback uut (
    .clk(clk), .rst(rst), .fail_in(fail_in), .fault_clr(fault_clr),
    .cfg_main_sel(cfg_main_sel), .cfg_mck_sel(cfg_mck_sel), .cfg_rc_en(cfg_rc_en),
    .eff_main_sel(eff_main_sel), .eff_mck_sel(eff_mck_sel),
    .eff_rc_en(eff_rc_en), .fault_out(fault_out)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic m, logic [1:0] k, logic r, logic f);
    checks++;
    if (eff_main_sel !== m || eff_mck_sel !== k || eff_rc_en !== r || fault_out !== f) begin
      errors++;
      $display("FAIL %s: got main=%b mck=%0d rc=%b fault=%b, expected main=%b mck=%0d rc=%b fault=%b",
               req, eff_main_sel, eff_mck_sel, eff_rc_en, fault_out, m, k, r, f);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; cfg_main_sel = 1'b1; cfg_mck_sel = 2'd2; cfg_rc_en = 1'b0;
    tick(2);
    expect_out("R1 reset loads config", 1'b1, 2'd2, 1'b0, 1'b0);
    cfg_main_sel = 1'b0; cfg_rc_en = 1'b1;
    tick();
    expect_out("R1 reset tracks config", 1'b0, 2'd2, 1'b1, 1'b0);
    rst = 1'b0;
  endtask

  task automatic test_follow();
    cfg_main_sel = 1'b1; cfg_mck_sel = 2'd0; cfg_rc_en = 1'b0;
    tick();
    expect_out("R2 follow pattern a", 1'b1, 2'd0, 1'b0, 1'b0);
    cfg_main_sel = 1'b0; cfg_mck_sel = 2'd3; cfg_rc_en = 1'b1;
    tick();
    expect_out("R2 follow pattern b", 1'b0, 2'd3, 1'b1, 1'b0);
  endtask

  task automatic test_main_path();
    cfg_main_sel = 1'b1; cfg_mck_sel = 2'd1; cfg_rc_en = 1'b0;
    tick();
    fail_in = 1'b1;
    tick();
    expect_out("R3 one edge after failure no switch yet", 1'b1, 2'd1, 1'b0, 1'b0);
    tick();
    expect_out("R3 R4 switched at second edge", 1'b0, 2'd1, 1'b1, 1'b1);
    fail_in = 1'b0;
    cfg_main_sel = 1'b1; cfg_rc_en = 1'b0; cfg_mck_sel = 2'd0;
    tick(3);
    expect_out("R6 R7 override held, mck follows off PLL path", 1'b0, 2'd0, 1'b1, 1'b1);
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    expect_out("R9 clear releases", 1'b1, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic test_pll_path();
    cfg_main_sel = 1'b1; cfg_mck_sel = 2'd2; cfg_rc_en = 1'b0;
    tick();
    fail_in = 1'b1;
    tick();
    expect_out("R5 edge k unchanged", 1'b1, 2'd2, 1'b0, 1'b0);
    tick();
    expect_out("R5 R4 edge k+1 master to main", 1'b1, 2'd1, 1'b1, 1'b1);
    tick();
    expect_out("R5 edge k+2 main to RC", 1'b0, 2'd1, 1'b1, 1'b1);
    cfg_mck_sel = 2'd2; fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    expect_out("R8 clear while failing ignored", 1'b0, 2'd1, 1'b1, 1'b1);
    tick(2);
    expect_out("R7 PLL write ignored", 1'b0, 2'd1, 1'b1, 1'b1);
    fail_in = 1'b0;
    tick();
    expect_out("R6 fault held without clear", 1'b0, 2'd1, 1'b1, 1'b1);
    fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    expect_out("R9 release back to PLL config", 1'b1, 2'd2, 1'b0, 1'b0);
    tick();
    expect_out("R2 follow after release", 1'b1, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic test_rc_already();
    cfg_main_sel = 1'b0; cfg_mck_sel = 2'd2; cfg_rc_en = 1'b1;
    tick();
    fail_in = 1'b1;
    tick(2);
    expect_out("R3 RC already selected, no master override", 1'b0, 2'd2, 1'b1, 1'b1);
    fail_in = 1'b0; fault_clr = 1'b1;
    tick();
    fault_clr = 1'b0;
    expect_out("R9 release", 1'b0, 2'd2, 1'b1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_follow();
    test_main_path();
    test_pll_path();
    test_rc_already();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule